// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches recent virtual-to-physical page translations. A lookup presents a virtual page number, the current address-space identifier and an access type. Every stored entry is compared against the key in parallel. In the same cycle the block returns one outcome: a successful translation, a miss, a translation fault, or a protection fault. It also returns the physical page and the entry's status bits. The outputs are combinational from the lookup inputs, so a hit adds no cycles to the access.

Entries are loaded by an external page-table walker or by software through a fill port. A fill always writes a fresh entry. It takes the lowest-numbered empty slot if one exists. Otherwise it takes a slot chosen by a free-running pseudo-random sequence. Software removes a stale mapping with a single-entry invalidate, which is keyed by page and identifier. A flush empties the whole buffer, for example on a change of address space. A successful translation marks its entry as referenced, and a permitted write also marks it dirty.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup (`lk_valid`=1) that matches an occupied entry with entry-valid=1 and is permitted asserts `lk_hit` alone, in the same cycle. It drives that entry's physical page, writable, dirty and referenced bits on `lk_ppn`, `lk_writable`, `lk_dirty` and `lk_ref`, as they stood before this lookup.
- R2: A lookup matches only when both the page number and the identifier are equal. With no matching occupied entry, `lk_miss` alone is asserted.
- R3: A match whose stored entry-valid bit is 0 asserts `lk_fault` alone, with neither hit nor miss.
- R4: A write lookup (`lk_write`=1) that matches a valid entry with writable=0 asserts `lk_prot_fault` alone. It leaves the dirty and referenced bits unchanged.
- R5: A hit sets the entry's referenced bit, and a write hit also sets its dirty bit. Both are visible from the next lookup on.
- R6: `inv_en` empties every entry matching `inv_vpn`/`inv_asid`. From the next cycle those lookups miss, while entries with another key are kept.
- R7: `flush_en` empties all entries, and it takes priority over a fill in the same cycle. Every lookup in the following cycle misses.
- R8: A fill writes the lowest-index empty slot when one exists. When the buffer is full, a fill replaces exactly one entry, chosen by a free-running pseudo-random sequence.
- R9: When two or more entries match one lookup, `lk_multi` is asserted and the outcome and data come from the lowest-index match.
- R10: After a synchronous reset (`rst`=1 at a clock edge) the buffer is empty. With `lk_valid`=0 all outcome outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page |
| lk_asid | input | 6 | Current address-space identifier |
| lk_write | input | 1 | Lookup is a write access |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry has valid=0 |
| lk_prot_fault | output | 1 | Write to a read-only entry |
| lk_multi | output | 1 | More than one entry matched |
| lk_ppn | output | 20 | Physical page of the selected entry |
| lk_writable | output | 1 | Selected entry permits writes |
| lk_dirty | output | 1 | Selected entry dirty bit |
| lk_ref | output | 1 | Selected entry referenced bit |
| fill_en | input | 1 | Write a new entry |
| fill_vpn | input | 20 | Fill virtual page |
| fill_asid | input | 6 | Fill identifier |
| fill_ppn | input | 20 | Fill physical page |
| fill_valid | input | 1 | Fill entry-valid bit |
| fill_writable | input | 1 | Fill access right (1 = read/write) |
| inv_en | input | 1 | Invalidate matching entries |
| inv_vpn | input | 20 | Invalidate virtual page |
| inv_asid | input | 6 | Invalidate identifier |
| flush_en | input | 1 | Empty the whole buffer |

## Verification
The bench checks that the same page under two identifiers gives two separate translations. If the identifier were ignored in the compare, one of them would return the other's physical page. It checks that an entry stored with valid=0 faults rather than misses, and that a rejected write leaves dirty and referenced clear. A design that updated status on any match would show dirty=1 on the next read. It checks that duplicate entries resolve to the lowest index with the multi flag raised. It also fills a full buffer and counts evictions. A victim picker that ignored empty slots would evict during the first sixteen fills, and one that wrote several slots would lose more than one old page.

// File: rtl/xtb_pkg.sv
package xtb_pkg;
    parameter int VPN_W  = 20;
    parameter int PPN_W  = 20;
    parameter int ASID_W = 6;

    typedef struct packed {
        logic              occ;       // slot holds a mapping
        logic              valid;     // mapping usable
        logic              writable;  // 1 = read/write, 0 = read-only
        logic              dirty;
        logic              refd;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
    } xtb_entry_t;

    // Galois right-shift feedback masks giving maximal length
    function automatic logic [7:0] lfsr_taps(input int w);
        case (w)
            2:       return 8'h03;
            3:       return 8'h06;
            4:       return 8'h0C;
            5:       return 8'h14;
            6:       return 8'h30;
            7:       return 8'h60;
            default: return 8'hB8;
        endcase
    endfunction
endpackage

// File: rtl/xtb_cam.sv
module xtb_cam
    import xtb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  xtb_entry_t [ENTRIES-1:0] tbl,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [ASID_W-1:0]        key_asid,
    output logic [ENTRIES-1:0]       hits,
    output logic [IDX_W-1:0]         first,
    output logic                     any,
    output logic                     multi
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hits[g] = tbl[g].occ && (tbl[g].vpn == key_vpn) && (tbl[g].asid == key_asid);
    end

    always_comb begin
        first = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) first = IDX_W'(i);
        end
    end

    assign any   = |hits;
    assign multi = |(hits & (hits - ENTRIES'(1)));
endmodule

// File: rtl/xtb_victim.sv
module xtb_victim
    import xtb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] occ,
    output logic [IDX_W-1:0]   slot
);
    localparam logic [7:0]       TAPS8 = lfsr_taps(IDX_W);
    localparam logic [IDX_W-1:0] TAPS  = TAPS8[IDX_W-1:0];

    logic [IDX_W-1:0] lfsr;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    always_ff @(posedge clk) begin
        if (rst) lfsr <= IDX_W'(1);
        else     lfsr <= {1'b0, lfsr[IDX_W-1:1]} ^ (lfsr[0] ? TAPS : '0);
    end

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!occ[i]) free_idx = IDX_W'(i);
        end
    end

    assign free_any = ~&occ;
    assign slot     = free_any ? free_idx : lfsr;
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xtb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic              lk_prot_fault,
    output logic              lk_multi,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic              lk_writable,
    output logic              lk_dirty,
    output logic              lk_ref,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_valid,
    input  logic              fill_writable,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic              flush_en
);
    xtb_entry_t [ENTRIES-1:0] tbl;
    logic [ENTRIES-1:0]       occ_vec;
    logic [ENTRIES-1:0]       lk_hits;
    logic [ENTRIES-1:0]       inv_hits;
    logic [IDX_W-1:0]         lk_first;
    logic [IDX_W-1:0]         victim;
    logic                     lk_any;
    logic                     lk_dup;
    xtb_entry_t               sel;
    logic                     denied;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_occ
        assign occ_vec[g]  = tbl[g].occ;
        assign inv_hits[g] = inv_en && tbl[g].occ && (tbl[g].vpn == inv_vpn)
                             && (tbl[g].asid == inv_asid);
    end

    xtb_cam #(.ENTRIES(ENTRIES)) u_cam (
        .tbl      (tbl),
        .key_vpn  (lk_vpn),
        .key_asid (lk_asid),
        .hits     (lk_hits),
        .first    (lk_first),
        .any      (lk_any),
        .multi    (lk_dup)
    );

    xtb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk  (clk),
        .rst  (rst),
        .occ  (occ_vec),
        .slot (victim)
    );

    assign sel    = tbl[lk_first];
    assign denied = lk_write && !sel.writable;

    always_comb begin
        lk_hit        = lk_valid && lk_any && sel.valid && !denied;
        lk_prot_fault = lk_valid && lk_any && sel.valid && denied;
        lk_fault      = lk_valid && lk_any && !sel.valid;
        lk_miss       = lk_valid && !lk_any;
        lk_multi      = lk_valid && lk_dup;
        lk_ppn        = (lk_valid && lk_any) ? sel.ppn : '0;
        lk_writable   = lk_valid && lk_any && sel.writable;
        lk_dirty      = lk_valid && lk_any && sel.dirty;
        lk_ref        = lk_valid && lk_any && sel.refd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_en) begin
                    tbl[i].occ <= 1'b0;
                end else if (fill_en && victim == IDX_W'(i)) begin
                    tbl[i].occ      <= 1'b1;
                    tbl[i].valid    <= fill_valid;
                    tbl[i].writable <= fill_writable;
                    tbl[i].dirty    <= 1'b0;
                    tbl[i].refd     <= 1'b0;
                    tbl[i].asid     <= fill_asid;
                    tbl[i].vpn      <= fill_vpn;
                    tbl[i].ppn      <= fill_ppn;
                end else if (inv_hits[i]) begin
                    tbl[i].occ <= 1'b0;
                end else if (lk_hit && lk_first == IDX_W'(i)) begin
                    tbl[i].refd <= 1'b1;
                    if (lk_write) tbl[i].dirty <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/xtb_checker.sv
module xtb_checker
    import xtb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_write,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic              lk_fault,
    input logic              lk_prot_fault,
    input logic              lk_multi,
    input logic              fill_en,
    input logic              inv_en,
    input logic [VPN_W-1:0]  inv_vpn,
    input logic [ASID_W-1:0] inv_asid,
    input logic              flush_en
);
    // R1 R2 R3: a lookup gives exactly one outcome
    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $countones({lk_hit, lk_miss, lk_fault, lk_prot_fault}) == 1);

    // R10: idle lookup port produces no outcome
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault || lk_prot_fault || lk_multi));

    // R4: protection fault only for writes
    assert_prot_write_R4: assert property (@(posedge clk) disable iff (rst)
        lk_prot_fault |-> lk_write);

    // R7: lookup right after a flush misses
    assert_flush_empty_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(flush_en) && lk_valid) |-> lk_miss);

    // R6: invalidated key misses next cycle when no fill intervened
    assert_inv_gone_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(inv_en && !fill_en) && lk_valid && lk_vpn == $past(inv_vpn)
         && lk_asid == $past(inv_asid)) |-> lk_miss);

    // R10: buffer empty after reset
    assert_reset_empty_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && lk_valid) |-> lk_miss);

    // R9: multi-match implies a match exists
    assert_multi_match_R9: assert property (@(posedge clk) disable iff (rst)
        lk_multi |-> !lk_miss);
endmodule

bind xlat_buffer xtb_checker u_chk (.*);

// File: tb/xlat_buffer_tb.sv
module xlat_buffer_tb;
    import xtb_pkg::*;

    logic clk = 0;
    logic rst = 1;
    always #5 clk = ~clk;

    logic              lk_valid = 0, lk_write = 0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic lk_hit, lk_miss, lk_fault, lk_prot_fault, lk_multi, lk_writable, lk_dirty, lk_ref;
    logic [PPN_W-1:0]  lk_ppn;
    logic              fill_en = 0, fill_valid = 0, fill_writable = 0;
    logic [VPN_W-1:0]  fill_vpn = '0;
    logic [ASID_W-1:0] fill_asid = '0;
    logic [PPN_W-1:0]  fill_ppn = '0;
    logic              inv_en = 0, flush_en = 0;
    logic [VPN_W-1:0]  inv_vpn = '0;
    logic [ASID_W-1:0] inv_asid = '0;

    xlat_buffer u_dut (.*);

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    typedef struct packed {
        logic [19:0] vpn; logic [5:0] asid; logic wr;
        logic hit; logic miss; logic flt; logic prot;
        logic [19:0] ppn; logic dirty; logic refd;
    } vec_t;

    // entries loaded first: 100/3 rw AAAAA, 200/3 ro 12345, 300/3 invalid, 100/5 rw 55555
    localparam vec_t VECS [9] = '{
        '{20'h00100, 6'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'hAAAAA, 1'b0, 1'b0}, // R1
        '{20'h00100, 6'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h55555, 1'b0, 1'b0}, // R2
        '{20'h00100, 6'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0}, // R2
        '{20'h00300, 6'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 1'b0, 1'b0}, // R3
        '{20'h00200, 6'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 20'h00000, 1'b0, 1'b0}, // R4
        '{20'h00200, 6'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h12345, 1'b0, 1'b0}, // R4
        '{20'h00100, 6'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 20'hAAAAA, 1'b0, 1'b1}, // R5
        '{20'h00100, 6'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'hAAAAA, 1'b1, 1'b1}, // R5
        '{20'h00999, 6'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0}  // R2
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        lk_valid = 0; lk_write = 0; fill_en = 0; inv_en = 0; flush_en = 0;
    endtask

    task automatic fill(input logic [19:0] v, input logic [5:0] a, input logic [19:0] p,
                        input logic val, input logic wr);
        @(negedge clk);
        lk_valid = 0; inv_en = 0; flush_en = 0;
        fill_en = 1; fill_vpn = v; fill_asid = a; fill_ppn = p;
        fill_valid = val; fill_writable = wr;
        @(negedge clk);
        fill_en = 0;
    endtask

    // drives lookup at negedge, outputs settle before next posedge
    task automatic look(input logic [19:0] v, input logic [5:0] a, input logic wr);
        @(negedge clk);
        fill_en = 0; inv_en = 0; flush_en = 0;
        lk_valid = 1; lk_vpn = v; lk_asid = a; lk_write = wr;
        #1;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int misses;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R10: empty after reset, idle port quiet
        look(20'h00000, 6'd0, 0);
        check("R10 miss after reset", {lk_miss, lk_hit, lk_fault}, 3'b100);
        idle(); #1;
        check("R10 idle outputs", {lk_hit, lk_miss, lk_fault, lk_prot_fault, lk_multi}, 5'b0);

        fill(20'h00100, 6'd3, 20'hAAAAA, 1, 1);
        fill(20'h00200, 6'd3, 20'h12345, 1, 0);
        fill(20'h00300, 6'd3, 20'h0BEEF, 0, 1);
        fill(20'h00100, 6'd5, 20'h55555, 1, 1);

        for (int i = 0; i < 9; i++) begin
            look(VECS[i].vpn, VECS[i].asid, VECS[i].wr);
            check($sformatf("R1-table vec%0d flags", i),
                  {lk_hit, lk_miss, lk_fault, lk_prot_fault},
                  {VECS[i].hit, VECS[i].miss, VECS[i].flt, VECS[i].prot});
            if (VECS[i].hit)
                check($sformatf("R5 vec%0d ppn/dirty/ref", i),
                      {lk_ppn, lk_dirty, lk_ref}, {VECS[i].ppn, VECS[i].dirty, VECS[i].refd});
        end

        // R6: single-entry invalidate
        @(negedge clk);
        lk_valid = 0; inv_en = 1; inv_vpn = 20'h00100; inv_asid = 6'd3;
        look(20'h00100, 6'd3, 0);
        check("R6 invalidated key misses", lk_miss, 1);
        look(20'h00100, 6'd5, 0);
        check("R6 other identifier kept", {lk_hit, lk_ppn}, {1'b1, 20'h55555});

        // R9: duplicate entries, lowest index wins (slot0 freed above, next free slot4)
        fill(20'h00400, 6'd3, 20'h11111, 1, 1);
        fill(20'h00400, 6'd3, 20'h22222, 1, 1);
        look(20'h00400, 6'd3, 0);
        check("R9 multi flag and lowest ppn", {lk_multi, lk_hit, lk_ppn}, {2'b11, 20'h11111});

        // R7: flush together with fill, flush wins
        @(negedge clk);
        lk_valid = 0; flush_en = 1; fill_en = 1;
        fill_vpn = 20'h00777; fill_asid = 6'd3; fill_ppn = 20'h1; fill_valid = 1;
        look(20'h00777, 6'd3, 0);
        check("R7 fill during flush dropped", lk_miss, 1);
        look(20'h00100, 6'd5, 0);
        check("R7 flushed entry misses", lk_miss, 1);

        // R8: 16 fills use empty slots, 17th evicts exactly one
        for (int i = 0; i < 16; i++) fill(20'h01000 + 20'(i), 6'd1, 20'(i + 16), 1, 1);
        misses = 0;
        for (int i = 0; i < 16; i++) begin
            look(20'h01000 + 20'(i), 6'd1, 0);
            if (!lk_hit || lk_ppn != 20'(i + 16)) misses++;
        end
        check("R8 empty slots preferred", 64'(misses), 64'd0);
        fill(20'h02000, 6'd1, 20'hCAFE0, 1, 1);
        look(20'h02000, 6'd1, 0);
        check("R8 new entry present", {lk_hit, lk_ppn}, {1'b1, 20'hCAFE0});
        misses = 0;
        for (int i = 0; i < 16; i++) begin
            look(20'h01000 + 20'(i), 6'd1, 0);
            if (lk_miss) misses++;
        end
        check("R8 exactly one evicted", 64'(misses), 64'd1);

        // R10: reset mid-run empties buffer
        @(negedge clk); lk_valid = 0; rst = 1;
        @(negedge clk); rst = 0;
        look(20'h02000, 6'd1, 0);
        check("R10 reset empties buffer", lk_miss, 1);
        idle();
        report();
    end
endmodule